// File: doc/BRIEF.md
# Load/Store Execution Sequencer

This block controls one execution slot in a scoreboard-driven out-of-order core. The slot takes one of three kinds of operation: an integer add, a memory load or a memory store. After issue it steps through a fixed chain of phases. Each phase raises a request line toward the scheduler. The phase moves on only when the scheduler answers that request with the matching go pulse. A go pulse that arrives while its request is low does nothing.

The opcode and the immediate offset are captured at issue. Both source operands are captured, each in its own register, when operand read is granted. An add produces its sum at that point and then asks for write-back. A load or a store first asks for an address slot, where the address is formed as the first operand plus the immediate. A load then waits for memory data before it asks for write-back. A store presents the second operand as its store data, together with the address, and finishes when the store grant arrives. Busy is high from issue until the final grant.

Top module: `ldst_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy and all four request outputs are low, and the result and address outputs are zero.
- R2: An issue pulse while the unit is idle, with an opcode of 0 (add), 1 (load) or 2 (store), sets busy and the read request from the next cycle onward. Opcode 3 is not a valid operation: issue with opcode 3 is ignored and the unit stays idle.
- R3: An issue pulse while busy is high is ignored. The opcode and immediate captured earlier stay in force.
- R4: A go-read, go-address, go-write or go-store pulse, or a load-data-valid strobe, has no effect unless the phase that consumes it is the current one.
- R5: For an add, a granted read leads in the next cycle to the write request alone, with the result equal to source 1 plus source 2 modulo 2^DATA_W.
- R6: For a load or a store, a granted read leads in the next cycle to the address request alone.
- R7: A granted address request drops the address request and, from the next cycle, drives the address output with the latched source 1 plus the latched immediate, modulo 2^DATA_W.
- R8: After a load's address grant, the write request stays low until load-data-valid is seen. In the next cycle the write request is high and the result equals the load data.
- R9: After a store's address grant, the store request is high from the next cycle and the store data output equals the latched source 2. A store never raises the write request.
- R10: A granted write request or store request clears that request and busy in the next cycle, so the unit can take a new issue.
- R11: At most one of the four request outputs is high in any cycle, and any request implies busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Issue pulse |
| op_i | input | 2 | Opcode at issue: 0 add, 1 load, 2 store |
| imm_i | input | DATA_W | Immediate offset, captured at issue |
| src1_i | input | DATA_W | First source operand, captured at read grant |
| src2_i | input | DATA_W | Second source operand, captured at read grant |
| go_rd_i | input | 1 | Operand read grant |
| rd_req_o | output | 1 | Operand read request |
| go_addr_i | input | 1 | Address grant |
| addr_req_o | output | 1 | Address request |
| addr_o | output | DATA_W | Latched memory address |
| ld_valid_i | input | 1 | Load data valid strobe |
| ld_data_i | input | DATA_W | Load data from memory |
| go_wr_i | input | 1 | Write-back grant |
| wr_req_o | output | 1 | Write-back request |
| result_o | output | DATA_W | Result for write-back |
| go_st_i | input | 1 | Store grant |
| st_req_o | output | 1 | Store request |
| st_data_o | output | DATA_W | Store data (latched source 2) |
| busy_o | output | 1 | Unit holds an operation |

## Verification
A wrong phase shows at the ports within one cycle of the grant that caused it. The wrong request line goes high, two request lines go high together, or busy stays up after the final grant. A bad operand or immediate register does not show when it is written. It shows only later, as a wrong sum, a wrong address or wrong store data, one cycle after the grant that uses it. Stray grants and stray issues are therefore injected during the phases that must ignore them. The data outputs are then compared after the following grants.

// File: rtl/ldst_seq_pkg.sv
package ldst_seq_pkg;

  typedef enum logic [1:0] {
    OPC_ADD   = 2'd0,
    OPC_LOAD  = 2'd1,
    OPC_STORE = 2'd2,
    OPC_RSVD  = 2'd3
  } opc_e;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_READ    = 3'd1,
    PH_ADDR    = 3'd2,
    PH_MEMWAIT = 3'd3,
    PH_WRITE   = 3'd4,
    PH_STORE   = 3'd5
  } phase_e;

  function automatic logic opc_is_valid(input logic [1:0] code);
    return code != OPC_RSVD;
  endfunction

  function automatic logic opc_uses_mem(input opc_e code);
    return (code == OPC_LOAD) || (code == OPC_STORE);
  endfunction

endpackage

// File: rtl/ldst_phase_ctrl.sv
module ldst_phase_ctrl
  import ldst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue_i,
  input  logic [1:0] op_i,
  input  opc_e       opc_q,
  input  logic       go_rd_i,
  input  logic       go_addr_i,
  input  logic       ld_valid_i,
  input  logic       go_wr_i,
  input  logic       go_st_i,
  output logic       issue_fire,
  output logic       rd_fire,
  output logic       addr_fire,
  output logic       ld_fire,
  output logic       wr_fire,
  output logic       st_fire,
  output logic       rd_req,
  output logic       addr_req,
  output logic       wr_req,
  output logic       st_req,
  output logic       busy
);

  phase_e phase_q, phase_d;

  assign rd_req   = (phase_q == PH_READ);
  assign addr_req = (phase_q == PH_ADDR);
  assign wr_req   = (phase_q == PH_WRITE);
  assign st_req   = (phase_q == PH_STORE);
  assign busy     = (phase_q != PH_IDLE);

  assign issue_fire = !busy && issue_i && opc_is_valid(op_i);
  assign rd_fire    = rd_req && go_rd_i;
  assign addr_fire  = addr_req && go_addr_i;
  assign ld_fire    = (phase_q == PH_MEMWAIT) && ld_valid_i;
  assign wr_fire    = wr_req && go_wr_i;
  assign st_fire    = st_req && go_st_i;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (issue_fire) phase_d = PH_READ;
      PH_READ:    if (rd_fire) phase_d = opc_uses_mem(opc_q) ? PH_ADDR : PH_WRITE;
      PH_ADDR:    if (addr_fire) phase_d = (opc_q == OPC_LOAD) ? PH_MEMWAIT : PH_STORE;
      PH_MEMWAIT: if (ld_fire) phase_d = PH_WRITE;
      PH_WRITE:   if (wr_fire) phase_d = PH_IDLE;
      PH_STORE:   if (st_fire) phase_d = PH_IDLE;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/ldst_operand_latch.sv
module ldst_operand_latch
  import ldst_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_fire,
  input  logic              rd_fire,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  output opc_e              opc_q,
  output logic [DATA_W-1:0] imm_q,
  output logic [DATA_W-1:0] src1_q,
  output logic [DATA_W-1:0] src2_q
);

  localparam int N_SRC = 2;

  logic [DATA_W-1:0] src_in [N_SRC];
  logic [DATA_W-1:0] src_q  [N_SRC];

  assign src_in[0] = src1_i;
  assign src_in[1] = src2_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q <= OPC_ADD;
      imm_q <= '0;
    end else if (issue_fire) begin
      opc_q <= opc_e'(op_i);
      imm_q <= imm_i;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       src_q[g] <= '0;
      else if (rd_fire) src_q[g] <= src_in[g];
    end
  end

  assign src1_q = src_q[0];
  assign src2_q = src_q[1];

endmodule

// File: rtl/ldst_result_path.sv
module ldst_result_path
  import ldst_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              addr_fire,
  input  logic              ld_fire,
  input  opc_e              opc_q,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [DATA_W-1:0] src1_q,
  input  logic [DATA_W-1:0] imm_q,
  input  logic [DATA_W-1:0] ld_data_i,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] result_q
);

  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  logic add_done;
  assign add_done = rd_fire && (opc_q == OPC_ADD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (addr_fire) addr_q <= wrap_add(src1_q, imm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result_q <= '0;
    else if (add_done) result_q <= wrap_add(src1_i, src2_i);
    else if (ld_fire)  result_q <= ld_data_i;
  end

endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
  import ldst_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic              go_rd_i,
  output logic              rd_req_o,
  input  logic              go_addr_i,
  output logic              addr_req_o,
  output logic [DATA_W-1:0] addr_o,
  input  logic              ld_valid_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              go_wr_i,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] result_o,
  input  logic              go_st_i,
  output logic              st_req_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic              busy_o
);

  opc_e              opc_q;
  logic [DATA_W-1:0] imm_q, src1_q, src2_q;
  logic issue_fire, rd_fire, addr_fire, ld_fire, wr_fire, st_fire;

  ldst_phase_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_i    (issue_i),
    .op_i       (op_i),
    .opc_q      (opc_q),
    .go_rd_i    (go_rd_i),
    .go_addr_i  (go_addr_i),
    .ld_valid_i (ld_valid_i),
    .go_wr_i    (go_wr_i),
    .go_st_i    (go_st_i),
    .issue_fire (issue_fire),
    .rd_fire    (rd_fire),
    .addr_fire  (addr_fire),
    .ld_fire    (ld_fire),
    .wr_fire    (wr_fire),
    .st_fire    (st_fire),
    .rd_req     (rd_req_o),
    .addr_req   (addr_req_o),
    .wr_req     (wr_req_o),
    .st_req     (st_req_o),
    .busy       (busy_o)
  );

  ldst_operand_latch #(.DATA_W(DATA_W)) u_opnd (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_fire (issue_fire),
    .rd_fire    (rd_fire),
    .op_i       (op_i),
    .imm_i      (imm_i),
    .src1_i     (src1_i),
    .src2_i     (src2_i),
    .opc_q      (opc_q),
    .imm_q      (imm_q),
    .src1_q     (src1_q),
    .src2_q     (src2_q)
  );

  ldst_result_path #(.DATA_W(DATA_W)) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_fire    (rd_fire),
    .addr_fire  (addr_fire),
    .ld_fire    (ld_fire),
    .opc_q      (opc_q),
    .src1_i     (src1_i),
    .src2_i     (src2_i),
    .src1_q     (src1_q),
    .imm_q      (imm_q),
    .ld_data_i  (ld_data_i),
    .addr_q     (addr_o),
    .result_q   (result_o)
  );

  assign st_data_o = src2_q;

endmodule

// File: rtl/ldst_seq_chk.sv
module ldst_seq_chk
  import ldst_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_i,
  input logic              go_rd_i,
  input logic              go_addr_i,
  input logic              go_wr_i,
  input logic              go_st_i,
  input logic              ld_valid_i,
  input logic              rd_req_o,
  input logic              addr_req_o,
  input logic              wr_req_o,
  input logic              st_req_o,
  input logic              busy_o,
  input logic [DATA_W-1:0] addr_o,
  input opc_e              opc_q,
  input logic [DATA_W-1:0] src1_q,
  input logic [DATA_W-1:0] imm_q
);

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rd_req_o, addr_req_o, wr_req_o, st_req_o}) <= 1); // R11

  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o || addr_req_o || wr_req_o || st_req_o) |-> busy_o); // R11

  AST_ISSUE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && issue_i && !(wr_req_o && go_wr_i) && !(st_req_o && go_st_i)) |=> busy_o); // R3

  AST_IDLE_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !issue_i && (go_rd_i || go_addr_i || go_wr_i || go_st_i || ld_valid_i)) |=> !busy_o); // R4

  AST_READ_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && go_rd_i) |=> (!rd_req_o && (wr_req_o || addr_req_o))); // R6

  AST_ADDR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_req_o && go_addr_i) |=> (!addr_req_o && addr_o == $past(src1_q + imm_q))); // R7

  AST_LOAD_WAITS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wr_req_o) && opc_q == OPC_LOAD) |-> $past(ld_valid_i)); // R8

  AST_STORE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_req_o) |-> $past(addr_req_o && go_addr_i)); // R9

  AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && go_wr_i) |=> (!busy_o && !wr_req_o)); // R10

  AST_STORE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req_o && go_st_i) |=> (!busy_o && !st_req_o)); // R10

endmodule

bind ldst_seq ldst_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_i    (issue_i),
  .go_rd_i    (go_rd_i),
  .go_addr_i  (go_addr_i),
  .go_wr_i    (go_wr_i),
  .go_st_i    (go_st_i),
  .ld_valid_i (ld_valid_i),
  .rd_req_o   (rd_req_o),
  .addr_req_o (addr_req_o),
  .wr_req_o   (wr_req_o),
  .st_req_o   (st_req_o),
  .busy_o     (busy_o),
  .addr_o     (addr_o),
  .opc_q      (opc_q),
  .src1_q     (src1_q),
  .imm_q      (imm_q)
);

// File: tb/ldst_seq_bench.sv
`timescale 1ns/1ps
module ldst_seq_bench;

  localparam int W = 32;
  localparam logic [1:0] K_ADD = 2'd0, K_LD = 2'd1, K_ST = 2'd2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, issue_i, go_rd_i, go_addr_i, ld_valid_i, go_wr_i, go_st_i;
  logic [1:0] op_i;
  logic [W-1:0] imm_i, src1_i, src2_i, ld_data_i;
  logic rd_req_o, addr_req_o, wr_req_o, st_req_o, busy_o;
  logic [W-1:0] addr_o, result_o, st_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  ldst_seq #(.DATA_W(W)) u_ldst_seq (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i), .imm_i(imm_i),
    .src1_i(src1_i), .src2_i(src2_i), .go_rd_i(go_rd_i), .rd_req_o(rd_req_o),
    .go_addr_i(go_addr_i), .addr_req_o(addr_req_o), .addr_o(addr_o),
    .ld_valid_i(ld_valid_i), .ld_data_i(ld_data_i), .go_wr_i(go_wr_i),
    .wr_req_o(wr_req_o), .result_o(result_o), .go_st_i(go_st_i),
    .st_req_o(st_req_o), .st_data_o(st_data_o), .busy_o(busy_o)
  );

  function automatic logic [W-1:0] exp_sum(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] wide;
    wide = {1'b0, a} + {1'b0, b};
    return wide[W-1:0];
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected order: {busy, rd, addr, wr, st}
  task automatic chk_ctl(input string req, input logic [4:0] exp);
    chk(req, W'({busy_o, rd_req_o, addr_req_o, wr_req_o, st_req_o}), W'(exp));
    chk("R11", W'($countones({rd_req_o, addr_req_o, wr_req_o, st_req_o}) <= 1), W'(1));
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    issue_i = 0; go_rd_i = 0; go_addr_i = 0; ld_valid_i = 0; go_wr_i = 0; go_st_i = 0;
  endtask

  task automatic run_op(input logic [1:0] k, input logic [W-1:0] s1, input logic [W-1:0] s2,
                        input logic [W-1:0] imm, input logic [W-1:0] ld, input bit noise,
                        input int wait_cyc);
    op_i = k; imm_i = imm; issue_i = 1; step(); quiet();
    chk_ctl("R2", 5'b11000);
    if (noise) begin
      // stray grants plus a second issue with another opcode and immediate
      go_addr_i = 1; go_wr_i = 1; go_st_i = 1; ld_valid_i = 1;
      issue_i = 1; op_i = k ^ 2'd1; imm_i = ~imm;
      step(); quiet();
      chk_ctl("R3/R4", 5'b11000);
    end
    src1_i = s1; src2_i = s2; go_rd_i = 1; step(); quiet();
    src1_i = $urandom; src2_i = $urandom;
    if (k == K_ADD) begin
      chk_ctl("R5", 5'b10010);
      chk("R5", result_o, exp_sum(s1, s2));
      go_wr_i = 1; step(); quiet();
      chk_ctl("R10", 5'b00000);
      return;
    end
    chk_ctl("R6", 5'b10100);
    if (noise) begin
      go_wr_i = 1; go_st_i = 1; ld_valid_i = 1; go_rd_i = 1; step(); quiet();
      chk_ctl("R4", 5'b10100);
    end
    go_addr_i = 1; step(); quiet();
    chk("R7", addr_o, exp_sum(s1, imm)); // R3: immediate from the first issue
    if (k == K_LD) begin
      chk_ctl("R8", 5'b10000);
      for (int i = 0; i < wait_cyc; i++) begin
        go_wr_i = noise; go_st_i = noise; step(); quiet();
        chk_ctl("R8", 5'b10000);
      end
      ld_data_i = ld; ld_valid_i = 1; step(); quiet();
      ld_data_i = ~ld;
      chk_ctl("R8", 5'b10010);
      chk("R8", result_o, ld);
      go_wr_i = 1; step(); quiet();
      chk_ctl("R10", 5'b00000);
    end else begin
      chk_ctl("R9", 5'b10001);
      chk("R9", st_data_o, s2);
      if (noise) begin
        go_wr_i = 1; ld_valid_i = 1; step(); quiet();
        chk_ctl("R9", 5'b10001);
      end
      go_st_i = 1; step(); quiet();
      chk_ctl("R10", 5'b00000);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd24680));
    quiet(); op_i = 0; imm_i = 0; src1_i = 0; src2_i = 0; ld_data_i = 0;
    rst_n = 0;
    repeat (3) step();
    chk_ctl("R1", 5'b00000);
    rst_n = 1; step();
    chk_ctl("R1", 5'b00000);
    chk("R1", result_o, '0);
    chk("R1", addr_o, '0);

    // reserved opcode is refused
    op_i = 2'd3; issue_i = 1; step(); quiet();
    chk_ctl("R2", 5'b00000);
    // grants while idle change nothing
    go_rd_i = 1; go_addr_i = 1; go_wr_i = 1; go_st_i = 1; ld_valid_i = 1; step(); quiet();
    chk_ctl("R4", 5'b00000);

    // directed corners: wraparound sum and address
    run_op(K_ADD, 32'hFFFF_FFFF, 32'h2, 32'h0, 32'h0, 1'b1, 0);
    run_op(K_LD, 32'hFFFF_FFF0, 32'h5, 32'h20, 32'hDEAD_BEEF, 1'b1, 3);
    run_op(K_ST, 32'h1000, 32'hCAFE_F00D, 32'hFFFF_FFFC, 32'h0, 1'b1, 0);
    run_op(K_LD, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 0);

    for (int n = 0; n < 60; n++) begin
      run_op(2'($urandom % 3), $urandom, $urandom, $urandom, $urandom,
             1'($urandom), int'($urandom % 4));
      repeat ($urandom % 2) step();
    end
    finish_run();
  end

endmodule